// File: doc/BRIEF.md
# Transition-Only Sample Storage Unit

This block sits between a digital sampler and a capture memory and decides which samples are written. Each sampled word arrives with a valid strobe. When the unit is in store-all mode it produces one memory write for every valid sample. When it is in transitional mode it writes a word only if the word differs from the last word it stored. Every write carries a timestamp, so that the quiet stretches between writes can be rebuilt afterwards. A long quiet stretch costs no memory, but a burst of activity that follows it is still recorded at full sample resolution.

The timestamp counts valid samples since the unit was last armed. Its width is finite, so in transitional mode a filler entry repeating the held word is forced before the gap since the last write could exceed the timestamp range. Two consecutive entries therefore never lie a whole counter period apart. The first valid sample after arming is always stored, so the reconstruction starts from a known reference value.

The control is a three-state machine. `ST_IDLE` is entered at reset and ignores samples. `ST_FIRST` is armed and waiting for the reference sample. `ST_RUN` compares each sample and stores it when required. The transitions are as follows. An arm pulse moves the machine from any state to `ST_FIRST`. A valid sample in `ST_FIRST` moves it to `ST_RUN`. Every other case holds the current state.

Top module: `tstore_top`

## Requirements
- R1: After reset, and until the first arm pulse, `wr_vld_o` stays 0 whatever the sample inputs do.
- R2: The first valid sample after an arm pulse is always written, with timestamp 0.
- R3: With `mode_all_i`=1 (store-all), every valid sample while armed produces one write whose data equals the sample.
- R4: With `mode_all_i`=0 (transitional), a valid sample is written only if it differs from the last written word or R6 forces it. A sample equal to the last written word is not written.
- R5: The timestamp of a write is the number of valid samples accepted since the arm pulse, modulo 2^TS_W. It counts from 0 for the first sample, and cycles without a valid sample do not advance it.
- R6: In transitional mode, a sample that arrives 2^TS_W-1 valid samples after the last write is written even if it is unchanged. The timestamp step between consecutive writes therefore always lies in 1..2^TS_W-1.
- R7: A data change that falls on the same sample as a forced filler gives exactly one write, carrying the new data.
- R8: An arm pulse restarts the timestamp and the reference. The sample presented in the arm cycle is discarded, and the next valid sample is written even if it equals the previously stored word.
- R9: A write appears on the outputs in the cycle after the clock edge that takes the sample. A cycle without a valid sample produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Arm pulse; restarts timestamp and reference |
| mode_all_i | input | 1 | 1 = store every sample, 0 = store transitions only |
| smp_vld_i | input | 1 | Sample valid strobe |
| smp_dat_i | input | DATA_W | Sampled word |
| wr_vld_o | output | 1 | Memory write strobe |
| wr_dat_o | output | DATA_W | Word to write |
| wr_ts_o | output | TS_W | Timestamp of the written word, in sample intervals since arming |

## Verification
The two functions that can fall in the same cycle are the forced filler of a quiet span and a genuine data change. The bench provokes this by holding one word for exactly 2^TS_W-2 samples after a write and changing it on the next sample. It then expects a single write with the new data and a timestamp exactly 2^TS_W-1 later. Arming in the same cycle as a valid sample is also provoked. The sample must vanish and the next one must carry timestamp 0. The bench runs a small 4-bit timestamp through full sweeps: all word pairs in transitional mode, all values in store-all mode, and a long mixed run with gaps and mode changes. Expected writes are computed from the requirement rules alone.

// File: rtl/tstore_pkg.sv
package tstore_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_RUN   = 2'd2
    } tstore_st_e;
endpackage

// File: rtl/tstore_stamp.sv
// Sample index and quiet-gap counter.
module tstore_stamp #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    input  logic            keep,
    output logic [TS_W-1:0] idx,
    output logic            gap_due
);
    localparam logic [TS_W-1:0] GAP_TOP = {TS_W{1'b1}};
    localparam logic [TS_W-1:0] GAP_LIM = GAP_TOP - 1'b1;

    logic [TS_W-1:0] gap;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
            gap <= '0;
        end else if (adv) begin
            idx <= idx + 1'b1;
            gap <= keep ? '0 : gap + 1'b1;
        end
    end

    assign gap_due = (gap == GAP_LIM);

    // R6: the quiet gap never reaches the full counter range
    p_gap_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gap != GAP_TOP);

    // R5: the index advances by one per accepted sample
    p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> idx == $past(idx) + 1'b1);
endmodule

// File: rtl/tstore_track.sv
// Holds the last stored word and flags a difference.
module tstore_track #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic              differs
);
    logic [DATA_W-1:0] held;

    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (load)
            held <= din;
    end

    assign differs = (din != held);
endmodule

// File: rtl/tstore_top.sv
module tstore_top #(
    parameter int DATA_W = 8,
    parameter int TS_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              mode_all_i,
    input  logic              smp_vld_i,
    input  logic [DATA_W-1:0] smp_dat_i,
    output logic              wr_vld_o,
    output logic [DATA_W-1:0] wr_dat_o,
    output logic [TS_W-1:0]   wr_ts_o
);
    import tstore_pkg::*;

    tstore_st_e      st, st_nx;
    logic            accept, keep;
    logic            differs, gap_due;
    logic [TS_W-1:0] idx;

    tstore_stamp #(.TS_W(TS_W)) u_stamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (arm_i),
        .adv     (accept),
        .keep    (keep),
        .idx     (idx),
        .gap_due (gap_due)
    );

    tstore_track #(.DATA_W(DATA_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (keep),
        .din     (smp_dat_i),
        .differs (differs)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nx;
    end

    // next state and store decision
    always_comb begin
        st_nx  = st;
        accept = 1'b0;
        keep   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                accept = 1'b0;
            end
            ST_FIRST: begin
                accept = smp_vld_i;
                keep   = smp_vld_i;
                if (smp_vld_i)
                    st_nx = ST_RUN;
            end
            ST_RUN: begin
                accept = smp_vld_i;
                keep   = smp_vld_i && (mode_all_i || differs || gap_due);
            end
            default: st_nx = ST_IDLE;
        endcase
        if (arm_i) begin
            st_nx  = ST_FIRST;
            accept = 1'b0;
            keep   = 1'b0;
        end
    end

    // write outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_vld_o <= 1'b0;
            wr_dat_o <= '0;
            wr_ts_o  <= '0;
        end else begin
            wr_vld_o <= keep;
            if (keep) begin
                wr_dat_o <= smp_dat_i;
                wr_ts_o  <= idx;
            end
        end
    end

    // R1: nothing is written while unarmed
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> !wr_vld_o);

    // R2: reference sample is written with timestamp zero
    p_first_ts0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIRST && smp_vld_i && !arm_i) |=> (wr_vld_o && wr_ts_o == '0));

    // R3: store-all writes every sample unchanged
    p_all_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && smp_vld_i && mode_all_i && !arm_i)
        |=> (wr_vld_o && wr_dat_o == $past(smp_dat_i)));

    // R4: an unchanged word with no filler due is dropped
    p_no_dup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && smp_vld_i && !mode_all_i && !arm_i && !differs && !gap_due)
        |=> !wr_vld_o);

    // R9: no write without a sample
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld_i |=> !wr_vld_o);

    // R8: arm discards the sample in its cycle
    p_arm_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> !wr_vld_o);
endmodule

// File: tb/sim_tstore_top.sv
module sim_tstore_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 4;
    localparam int TW   = 4;
    localparam int GMAX = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0, mode_all = 1'b0, vld = 1'b0;
    logic [DW-1:0] dat = '0;
    logic          wr_vld;
    logic [DW-1:0] wr_dat;
    logic [TW-1:0] wr_ts;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // requirement model
    int            m_st = 0;      // 0 idle, 1 first, 2 run
    int            m_cnt = 0;
    int            m_gap = 0;
    logic [DW-1:0] m_last = '0;
    logic [15:0]   lfsr = 16'hACE1;

    tstore_top #(.DATA_W(DW), .TS_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .mode_all_i(mode_all),
        .smp_vld_i(vld), .smp_dat_i(dat),
        .wr_vld_o(wr_vld), .wr_dat_o(wr_dat), .wr_ts_o(wr_ts)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, clock, then check at next negedge
    task automatic step(input string tag, input bit a, input bit m,
                        input bit v, input int d);
        bit            e_v;
        int            e_ts;
        logic [DW-1:0] dd;
        dd = DW'(d);
        arm = a; mode_all = m; vld = v; dat = dd;
        e_v = 0; e_ts = 0;
        @(posedge clk);
        if (a) begin
            m_st = 1; m_cnt = 0; m_gap = 0;
        end else if (v && m_st != 0) begin
            if (m_st == 1) e_v = 1;
            else e_v = m || (dd != m_last) || (m_gap == GMAX - 1);
            e_ts = m_cnt % (1 << TW);
            m_cnt++;
            if (e_v) begin m_last = dd; m_gap = 0; m_st = 2; end
            else m_gap++;
        end
        @(negedge clk);
        chk({tag, " vld"}, int'(wr_vld), int'(e_v));
        if (e_v && wr_vld) begin
            chk({tag, " dat"}, int'(wr_dat), d);
            chk({tag, " ts"}, int'(wr_ts), e_ts);
        end
    endtask

    task automatic nxt_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++; n_chk++;
                $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset vld", int'(wr_vld), 0);
        // R1: samples while unarmed are ignored
        for (int i = 0; i < 8; i++) step("R1 idle", 0, i[0], 1, i);

        // R2 / R3: store-all sweep over every value, timestamp wraps (R5)
        step("R8 arm", 1, 1, 1, 9);
        for (int i = 0; i < 40; i++) step("R3 all", 0, 1, 1, i % 16);

        // R4: all ordered pairs in transitional mode
        step("R8 arm", 1, 0, 0, 0);
        step("R2 first", 0, 0, 1, 0);
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
                step("R4 pair a", 0, 0, 1, a);
                step("R4 pair b", 0, 0, 1, b);
            end

        // R6 / R5: long quiet span with gaps; fillers at each full range
        step("R8 arm", 1, 0, 0, 0);
        step("R2 first", 0, 0, 1, 5);
        for (int i = 0; i < 60; i++) begin
            if (i % 3 == 2) step("R5 gap", 0, 0, 0, 5);
            step("R6 quiet", 0, 0, 1, 5);
        end

        // R7: change lands on the forced filler sample
        step("R8 arm", 1, 0, 0, 0);
        step("R2 first", 0, 0, 1, 3);
        for (int i = 0; i < GMAX - 1; i++) step("R7 hold", 0, 0, 1, 3);
        step("R7 coincide", 0, 0, 1, 12);
        chk("R7 single ts", int'(wr_ts), GMAX);
        step("R7 after", 0, 0, 1, 12);

        // R8: re-arm with same word; sample in arm cycle discarded
        step("R8 arm drop", 1, 0, 1, 12);
        step("R8 same word", 0, 0, 1, 12);
        chk("R8 ts zero", int'(wr_ts), 0);

        // R9 / R3 / R4: mixed run, random gaps and mode changes
        for (int i = 0; i < 3000; i++) begin
            nxt_lfsr();
            step("R9 mix", lfsr[15:6] == 10'd0, lfsr[7] & lfsr[3],
                 lfsr[0] | lfsr[1], (lfsr[5:4] == 2'b00) ? int'(lfsr[11:8]) : 7);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule